// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the bus-slave side of a simple serial port. A processor reaches it over a word-addressed peripheral bus with a 16-bit data path. It holds three registers: a transmit holding byte, a receive holding byte and a baud divisor. It also reports a two-bit status word. The transmit and receive holding registers share one word offset. The bus direction picks which of them is reached, so the direction works like one extra address bit. Because the two are separate physical registers, one byte can wait to be sent while another received byte waits to be read. This gives full-duplex operation.

An external shifter takes bytes from the transmit handoff through a valid/accept pair. It delivers received bytes through a one-cycle strobe. The divisor is a counter reload value: a divisor of N gives a one-clock tick every N peripheral clocks. For example, a 12 MHz clock divided by 625 gives 19200 baud. Writing the divisor restarts the count at once. A divisor below 2 stops the tick.

Each part of the block is a small state machine:
- The transmit holder has the states TXH_EMPTY and TXH_FULL. A bus write moves it to full. An accept from the shifter moves it back to empty, unless a write lands in the same cycle.
- The receive holder has the states RXH_IDLE and RXH_HELD. A shifter strobe moves it to held. A bus read of the data offset moves it back to idle, unless a strobe lands in the same cycle.
- The tick generator has the states BG_RUN and BG_STOP. Each divisor write moves it to BG_RUN when the new value is 2 or more, and to BG_STOP otherwise.

Top module: `uart_regfront`

## Requirements
- R1: A write to word offset 0 stores bus_wdata[7:0] as the transmit byte. In the next cycle tx_valid is 1 and tx_byte shows that byte. A write while a byte is pending replaces it.
- R2: A read of word offset 0 returns {8'h00, held receive byte} and never the transmit byte. After the read, status bit 0 is 0, unless a strobe arrived in the same cycle.
- R3: A cycle with rx_strobe high captures rx_in_byte and sets status bit 0. The capture leaves tx_byte and tx_valid unchanged, so a pending transmit and a held receive byte coexist.
- R4: When tx_valid and tx_accept are both high and no data write happens in that cycle, tx_valid is 0 in the next cycle and status bit 1 is 1.
- R5: Word offset 1 holds the 16-bit divisor and reads back the last value written. Its value after reset is 625.
- R6: With a divisor N of 2 or more, baud_tick is a one-cycle pulse with a period of exactly N clocks.
- R7: A divisor write restarts the count. The first tick comes exactly N clocks after the write edge, whatever the phase before the write.
- R8: With a divisor of 0 or 1, baud_tick stays low.
- R9: Reads of word offsets 3 and above return 0. Writes to those offsets change no register, status or output.
- R10: After reset, tx_valid is 0 and baud_tick is 0. Status reads 16'h0002 (bit 1 = transmit empty, bit 0 = receive valid). The data offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word_addr | input | 10 | Byte address bits 11..2 |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_sel is high and bus_wr is low |
| tx_byte | output | 8 | Byte offered to the shifter |
| tx_valid | output | 1 | tx_byte is pending |
| tx_accept | input | 1 | Shifter takes tx_byte |
| rx_in_byte | input | 8 | Byte from the shifter |
| rx_strobe | input | 1 | Capture rx_in_byte |
| baud_tick | output | 1 | One-cycle bit-rate tick |

## Verification
A seeded random mix of data writes, data reads, receive strobes, shifter accepts and status reads runs against a bench model of both holders. This separates the two aliased registers: a design that returned the transmit byte on a read, or let one side disturb the other, would diverge from the model. Directed runs cover the tick period at small random divisors and at 625, a divisor rewritten in the middle of a count, and divisors of 0 and 1. Writes to random undecoded offsets are followed by reads of every decoded register, which shows that they left nothing changed.

// File: rtl/uart_rf_pkg.sv
package uart_rf_pkg;

    // word offsets (byte address bits 11..2)
    localparam int unsigned WOFF_DATA = 0;
    localparam int unsigned WOFF_DIV  = 1;
    localparam int unsigned WOFF_STAT = 2;

    // status bit positions
    localparam int unsigned STAT_RXV_BIT = 0;
    localparam int unsigned STAT_TXE_BIT = 1;

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_DIV  = 2'd1,
        REG_STAT = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic { TXH_EMPTY, TXH_FULL } txh_state_e;
    typedef enum logic { RXH_IDLE,  RXH_HELD } rxh_state_e;
    typedef enum logic { BG_STOP,   BG_RUN   } bg_state_e;

endpackage

// File: rtl/uart_rf_txhold.sv
module uart_rf_txhold
    import uart_rf_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              accept,
    output logic [BYTE_W-1:0] byte_q,
    output logic              full
);

    txh_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TXH_EMPTY: if (load) state_d = TXH_FULL;
            TXH_FULL: begin
                if (load)        state_d = TXH_FULL;
                else if (accept) state_d = TXH_EMPTY;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TXH_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    byte_q <= '0;
        else if (load) byte_q <= load_byte;
    end

    assign full = (state_q == TXH_FULL);

endmodule

// File: rtl/uart_rf_rxhold.sv
module uart_rf_rxhold
    import uart_rf_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [BYTE_W-1:0] cap_byte,
    input  logic              consume,
    output logic [BYTE_W-1:0] byte_q,
    output logic              held
);

    rxh_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RXH_IDLE: if (capture) state_d = RXH_HELD;
            RXH_HELD: begin
                if (capture)      state_d = RXH_HELD;
                else if (consume) state_d = RXH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RXH_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       byte_q <= '0;
        else if (capture) byte_q <= cap_byte;
    end

    assign held = (state_q == RXH_HELD);

endmodule

// File: rtl/uart_rf_baud.sv
module uart_rf_baud
    import uart_rf_pkg::*;
#(
    parameter int unsigned      CNT_W     = 16,
    parameter logic [CNT_W-1:0] DIV_RESET = 625
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_load,
    input  logic [CNT_W-1:0] div_new,
    input  logic [CNT_W-1:0] div_cur,
    output logic             tick
);

    localparam logic [CNT_W-1:0] DIV_MIN   = CNT_W'(2);
    localparam bg_state_e        ST_RESET  = (DIV_RESET >= DIV_MIN) ? BG_RUN : BG_STOP;

    bg_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    always_comb begin
        state_d = state_q;
        if (div_load) state_d = (div_new >= DIV_MIN) ? BG_RUN : BG_STOP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    assign wrap = (cnt_q == div_cur - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (div_load) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else begin
            unique case (state_q)
                BG_STOP: begin
                    cnt_q <= '0;
                    tick  <= 1'b0;
                end
                BG_RUN: begin
                    if (wrap) begin
                        cnt_q <= '0;
                        tick  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                        tick  <= 1'b0;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/uart_regfront.sv
module uart_regfront
    import uart_rf_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 10,
    parameter int unsigned       DATA_W    = 16,
    parameter int unsigned       BYTE_W    = 8,
    parameter logic [DATA_W-1:0] DIV_RESET = 625
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_word_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_valid,
    input  logic              tx_accept,
    input  logic [BYTE_W-1:0] rx_in_byte,
    input  logic              rx_strobe,
    output logic              baud_tick
);

    localparam int unsigned PAD_W = DATA_W - BYTE_W;

    reg_sel_e          sel_reg;
    logic              wr_data, rd_data, wr_div;
    logic [DATA_W-1:0] div_q;
    logic [BYTE_W-1:0] rx_byte_q;
    logic              rx_held, tx_full;
    logic [DATA_W-1:0] stat_word;

    always_comb begin
        if (bus_word_addr == ADDR_W'(WOFF_DATA))      sel_reg = REG_DATA;
        else if (bus_word_addr == ADDR_W'(WOFF_DIV))  sel_reg = REG_DIV;
        else if (bus_word_addr == ADDR_W'(WOFF_STAT)) sel_reg = REG_STAT;
        else                                          sel_reg = REG_NONE;
    end

    assign wr_data = bus_sel &&  bus_wr && (sel_reg == REG_DATA);
    assign rd_data = bus_sel && !bus_wr && (sel_reg == REG_DATA);
    assign wr_div  = bus_sel &&  bus_wr && (sel_reg == REG_DIV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      div_q <= DIV_RESET;
        else if (wr_div) div_q <= bus_wdata;
    end

    uart_rf_txhold #(.BYTE_W(BYTE_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (wr_data),
        .load_byte (bus_wdata[BYTE_W-1:0]),
        .accept    (tx_accept),
        .byte_q    (tx_byte),
        .full      (tx_full)
    );

    uart_rf_rxhold #(.BYTE_W(BYTE_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (rx_strobe),
        .cap_byte (rx_in_byte),
        .consume  (rd_data),
        .byte_q   (rx_byte_q),
        .held     (rx_held)
    );

    uart_rf_baud #(.CNT_W(DATA_W), .DIV_RESET(DIV_RESET)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_load (wr_div),
        .div_new  (bus_wdata),
        .div_cur  (div_q),
        .tick     (baud_tick)
    );

    assign tx_valid = tx_full;

    always_comb begin
        stat_word               = '0;
        stat_word[STAT_RXV_BIT] = rx_held;
        stat_word[STAT_TXE_BIT] = !tx_full;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (sel_reg)
                REG_DATA: bus_rdata = {{PAD_W{1'b0}}, rx_byte_q};
                REG_DIV:  bus_rdata = div_q;
                REG_STAT: bus_rdata = stat_word;
                REG_NONE: bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/uart_regfront_chk.sv
module uart_regfront_chk #(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned DATA_W = 16,
    parameter int unsigned BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_word_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [BYTE_W-1:0] tx_byte,
    input logic              tx_valid,
    input logic              tx_accept,
    input logic              rx_strobe,
    input logic              rx_held,
    input logic [DATA_W-1:0] div_q,
    input logic              baud_tick
);

    logic wr0, rd0, wr1, undec_rd;
    assign wr0      = bus_sel &&  bus_wr && (bus_word_addr == ADDR_W'(0));
    assign rd0      = bus_sel && !bus_wr && (bus_word_addr == ADDR_W'(0));
    assign wr1      = bus_sel &&  bus_wr && (bus_word_addr == ADDR_W'(1));
    assign undec_rd = bus_sel && !bus_wr && (bus_word_addr > ADDR_W'(2));

    AST_TX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr0 |=> (tx_valid && tx_byte == $past(bus_wdata[BYTE_W-1:0]))); // R1
    AST_RD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd0 |-> (bus_rdata[DATA_W-1:BYTE_W] == '0)); // R2
    AST_RX_CONSUME: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0 && !rx_strobe) |=> !rx_held); // R2
    AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_strobe |=> rx_held); // R3
    AST_TX_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_strobe && !wr0 && !tx_accept) |=> ($stable(tx_byte) && $stable(tx_valid))); // R3
    AST_TX_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_accept && !wr0) |=> !tx_valid); // R4
    AST_DIV_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr1 |=> (div_q == $past(bus_wdata))); // R5
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        baud_tick |=> !baud_tick); // R6
    AST_TICK_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q < DATA_W'(2)) |-> !baud_tick); // R8
    AST_UNDEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        undec_rd |-> (bus_rdata == '0)); // R9

endmodule

bind uart_regfront uart_regfront_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTE_W(BYTE_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_sel       (bus_sel),
    .bus_wr        (bus_wr),
    .bus_word_addr (bus_word_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .tx_byte       (tx_byte),
    .tx_valid      (tx_valid),
    .tx_accept     (tx_accept),
    .rx_strobe     (rx_strobe),
    .rx_held       (rx_held),
    .div_q         (div_q),
    .baud_tick     (baud_tick)
);

// File: tb/uart_regfront_tb.sv
`timescale 1ns/1ps
module uart_regfront_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [9:0]  bus_word_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  tx_byte;
    logic        tx_valid;
    logic        tx_accept = 1'b0;
    logic [7:0]  rx_in_byte = '0;
    logic        rx_strobe = 1'b0;
    logic        baud_tick;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // bench model
    bit       m_tx_full = 0;
    bit [7:0] m_tx_byte = 0;
    bit       m_rx_full = 0;
    bit [7:0] m_rx_byte = 0;
    bit [15:0] m_div = 16'd625;

    always #2 clk = ~clk;

    uart_regfront u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_word_addr(bus_word_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_accept(tx_accept),
        .rx_in_byte(rx_in_byte), .rx_strobe(rx_strobe), .baud_tick(baud_tick)
    );

    function automatic logic [15:0] exp_status();
        return {14'd0, !m_tx_full, m_rx_full};
    endfunction

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [9:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_word_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [9:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_word_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic rx_push(input logic [7:0] b);
        @(negedge clk);
        rx_strobe = 1; rx_in_byte = b;
        @(negedge clk);
        rx_strobe = 0;
    endtask

    task automatic tx_take();
        @(negedge clk);
        tx_accept = 1;
        @(negedge clk);
        tx_accept = 0;
    endtask

    task automatic check_ports(input string tag);
        logic [15:0] s;
        chk({15'd0, tx_valid}, {15'd0, m_tx_full}, {tag, " tx_valid"});
        if (m_tx_full) chk({8'd0, tx_byte}, {8'd0, m_tx_byte}, {tag, " tx_byte"});
        bus_read(10'd2, s);
        chk(s, exp_status(), {tag, " status"});
    endtask

    // checks tick over a window after a divisor write returned
    task automatic tick_window(input int d, input int cycles, input string tag);
        for (int k = 1; k <= cycles; k++) begin
            @(negedge clk);
            chk({15'd0, baud_tick}, {15'd0, (d >= 2) && (k % d == 0)}, tag);
        end
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] r;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R10 reset state
        chk({15'd0, tx_valid}, 16'd0, "R10 tx_valid");
        chk({15'd0, baud_tick}, 16'd0, "R10 tick");
        bus_read(10'd2, r); chk(r, 16'h0002, "R10 status");
        bus_read(10'd0, r); chk(r, 16'h0000, "R10 data");
        // R5 reset divisor
        bus_read(10'd1, r); chk(r, 16'd625, "R5 reset divisor");

        // R1 / R3 full duplex directed
        bus_write(10'd0, 16'hBE5A); m_tx_full = 1; m_tx_byte = 8'h5A;
        check_ports("R1 load");
        rx_push(8'hC3); m_rx_full = 1; m_rx_byte = 8'hC3;
        check_ports("R3 duplex");
        bus_read(10'd0, r); chk(r, 16'h00C3, "R2 read rx not tx");
        m_rx_full = 0;
        check_ports("R2 consume");
        tx_take(); m_tx_full = 0;
        check_ports("R4 drain");

        // R1 overwrite while pending
        bus_write(10'd0, 16'h0011); bus_write(10'd0, 16'h0022);
        m_tx_full = 1; m_tx_byte = 8'h22;
        check_ports("R1 overwrite");

        // random mix
        for (int i = 0; i < 300; i++) begin
            int op;
            logic [7:0] b;
            op = $urandom_range(0, 3);
            b  = 8'($urandom);
            unique case (op)
                0: begin bus_write(10'd0, {8'($urandom), b}); m_tx_full = 1; m_tx_byte = b; end
                1: begin
                    bus_read(10'd0, r);
                    chk(r, {8'd0, m_rx_byte}, "R2 random read");
                    m_rx_full = 0;
                end
                2: begin rx_push(b); m_rx_full = 1; m_rx_byte = b; end
                3: begin tx_take(); m_tx_full = 0; end
            endcase
            check_ports("R3 random");
        end

        // R9 undecoded offsets
        for (int i = 0; i < 20; i++) begin
            logic [9:0] a;
            a = 10'($urandom_range(3, 1023));
            bus_write(a, 16'($urandom));
            bus_read(a, r); chk(r, 16'd0, "R9 undecoded read");
            bus_read(10'd1, r); chk(r, m_div, "R9 divisor kept");
            check_ports("R9 no side effect");
        end

        // R6 tick period, random small divisors
        for (int i = 0; i < 8; i++) begin
            int d;
            d = $urandom_range(2, 20);
            bus_write(10'd1, 16'(d)); m_div = 16'(d);
            bus_read(10'd1, r); chk(r, m_div, "R5 divisor readback");
            bus_write(10'd1, 16'(d));
            tick_window(d, 3 * d, "R6 tick period");
        end
        bus_write(10'd1, 16'd625); m_div = 16'd625;
        tick_window(625, 1300, "R6 tick period 625");

        // R7 restart mid-count
        bus_write(10'd1, 16'd10);
        repeat (4) @(negedge clk);
        bus_write(10'd1, 16'd10); m_div = 16'd10;
        tick_window(10, 25, "R7 restart");

        // R8 divisors 0 and 1
        bus_write(10'd1, 16'd1); m_div = 16'd1;
        tick_window(1, 40, "R8 div one");
        bus_write(10'd1, 16'd0); m_div = 16'd0;
        tick_window(0, 40, "R8 div zero");
        bus_read(10'd1, r); chk(r, 16'd0, "R5 divisor zero readback");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule